// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block sets the bit rate of an I2C controller's clock line. A small prescaler divides the peripheral clock by one plus a short divide field, giving a reference tick. A phase sequencer then counts reference ticks to time the low and high halves of each SCL period. The coarse divide field adds eight ticks per step to the period. A separate compensation count makes up for the SCL rise time, fall time and internal delay.

Both divide fields come in one packed clock-control word. The coarse field sits directly above the prescaler field, and the prescaler field is two or three bits wide according to a build parameter. The reference rate must be kept below 20 MHz, and the field values must never give an SCL rate above the wanted bus rate. Choosing those values is left to the software that programs the word.

While run is high, the block drives SCL low during the low phase and releases it during the high phase. It gives one-cycle strobes at each falling edge, at each release and at a mid-high sample point. The high phase is counted only while the sensed SCL level is high, so a slow rise or a device that holds SCL low makes the period longer. The control inputs are plain level pins and carry no data stream, so the block has no handshake.

Top module: `i2c_scl_divider`

## Requirements
- R1: The prescaler field is read from `ccr[CDF_W-1:0]` and the coarse field from `ccr[CDF_W+SCGD_W-1:CDF_W]`. With default parameters this is `ccr[2:0]` and `ccr[8:3]`.
- R2: While running, `ref_tick_o` pulses once every CDF+1 clocks. Exactly 10+4·SCGD ticks fall in each low phase.
- R3: The low phase lasts (10+4·SCGD)·(CDF+1) clocks. It is measured from the cycle of `scl_fall_o` to the cycle of `scl_rise_o`.
- R4: When SCL follows the drive, the high phase lasts (10+4·SCGD+COMP)·(CDF+1) clocks. The full period is therefore (20+8·SCGD+COMP)·(CDF+1) clocks.
- R5: If the sensed SCL stays low for N clocks after release, the high phase is longer by exactly N clocks.
- R6: `sample_o` pulses once per high phase, ((H>>1)+1)·(CDF+1)+N clocks after `scl_rise_o`, where H = 10+4·SCGD+COMP.
- R7: When `run_en` rises while idle, the next cycle shows `scl_fall_o` and SCL driven low (`scl_low_o`=1).
- R8: When `run_en` is low, SCL is released in the next cycle and no strobe or tick is given.
- R9: `ccr` and `comp` are captured only at a falling-edge boundary. A change made mid-period first takes effect in the following period.
- R10: After reset, SCL is released and all strobes are low.
- R11: At most one of the fall, rise and sample strobes is high in any cycle. A fall strobe only comes with SCL driven low, and a rise strobe only comes right after a driven-low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Run enable; low holds the divider idle |
| ccr | input | CDF_W+SCGD_W (9) | Packed clock-control word: coarse field above prescaler field |
| comp | input | COMP_W (6) | Rise/fall compensation count in reference ticks |
| scl_in | input | 1 | Sensed SCL level |
| scl_low_o | output | 1 | 1 = drive SCL low, 0 = release |
| scl_fall_o | output | 1 | Strobe in the first cycle of a low phase |
| scl_rise_o | output | 1 | Strobe in the first cycle of a high phase |
| sample_o | output | 1 | Mid-high sample strobe |
| ref_tick_o | output | 1 | Reference-clock tick |

## Verification
The bound checker checks these on every cycle:
- strobes never overlap;
- fall and rise strobes agree with the SCL drive level;
- SCL is released one cycle after `run_en` drops;
- the gap between reference ticks never grows past the largest prescaler setting.

The exact phase lengths, the tick count per low phase and the sample position under clock stretching can only be shown by the bench's timed scenarios. The same holds for field packing and for boundary-aligned reconfiguration. These scenarios compare measured cycle counts with formulas evaluated for random and extreme field values.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

  // Half of the fixed base count of 20 reference ticks per period.
  localparam int unsigned BASE_HALF = 10;
  // Each coarse step adds 8 ticks per period, 4 to each half.
  localparam int unsigned STEP_HALF_SHIFT = 2;
endpackage

// File: rtl/sclk_cfg_latch.sv
module sclk_cfg_latch #(
  parameter int CDF_W  = 3,
  parameter int SCGD_W = 6,
  parameter int COMP_W = 6,
  parameter int PH_W   = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [CDF_W+SCGD_W-1:0]  ccr,
  input  logic [COMP_W-1:0]        comp,
  output logic [CDF_W-1:0]         cdf_act,
  output logic [PH_W-1:0]          low_len,
  output logic [PH_W-1:0]          high_len
);
  import sclk_pkg::*;

  logic [CDF_W-1:0]  cdf_f;
  logic [SCGD_W-1:0] scgd_f;
  logic [PH_W-1:0]   low_n;
  logic [PH_W-1:0]   high_n;

  // Field unpacking: coarse field directly above the prescaler field.
  assign cdf_f  = ccr[CDF_W-1:0];
  assign scgd_f = ccr[CDF_W +: SCGD_W];

  always_comb begin
    low_n  = PH_W'(BASE_HALF) + (PH_W'(scgd_f) << STEP_HALF_SHIFT);
    high_n = low_n + PH_W'(comp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cdf_act  <= '0;
      low_len  <= PH_W'(BASE_HALF);
      high_len <= PH_W'(BASE_HALF);
    end else if (load) begin
      cdf_act  <= cdf_f;
      low_len  <= low_n;
      high_len <= high_n;
    end
  end
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int CDF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             hold,
  input  logic [CDF_W-1:0] cdf_act,
  output logic             tick
);
  logic [CDF_W-1:0] pre_q;

  assign tick = !hold && (pre_q == cdf_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pre_q <= '0;
    else if (load || hold || tick) pre_q <= '0;
    else                           pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/sclk_phase_seq.sv
module sclk_phase_seq #(
  parameter int PH_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            scl_in,
  input  logic            tick,
  input  logic [PH_W-1:0] low_len,
  input  logic [PH_W-1:0] high_len,
  output logic            load,
  output logic            hold,
  output logic            scl_low_o,
  output logic            scl_fall_o,
  output logic            scl_rise_o,
  output logic            sample_o
);
  import sclk_pkg::*;

  phase_t          st_q;
  logic [PH_W-1:0] cnt_q;
  logic            end_low;
  logic            end_high;
  logic            mid_high;
  logic            high_ok;

  always_comb begin
    high_ok  = (st_q == PH_HIGH) && scl_in;
    hold     = (st_q == PH_IDLE) || ((st_q == PH_HIGH) && !scl_in);
    end_low  = (st_q == PH_LOW) && tick && (cnt_q == low_len - 1'b1);
    end_high = high_ok && tick && (cnt_q == high_len - 1'b1);
    mid_high = high_ok && tick && (cnt_q == (high_len >> 1));
    load     = run_en && ((st_q == PH_IDLE) || end_high);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PH_IDLE;
      cnt_q      <= '0;
      scl_fall_o <= 1'b0;
      scl_rise_o <= 1'b0;
      sample_o   <= 1'b0;
    end else if (!run_en) begin
      st_q       <= PH_IDLE;
      cnt_q      <= '0;
      scl_fall_o <= 1'b0;
      scl_rise_o <= 1'b0;
      sample_o   <= 1'b0;
    end else begin
      scl_fall_o <= load;
      scl_rise_o <= end_low;
      sample_o   <= mid_high;
      if (load) begin
        st_q  <= PH_LOW;
        cnt_q <= '0;
      end else if (end_low) begin
        st_q  <= PH_HIGH;
        cnt_q <= '0;
      end else if (tick && ((st_q == PH_LOW) || high_ok)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign scl_low_o = (st_q == PH_LOW);
endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider #(
  parameter int CDF_W  = 3,
  parameter int SCGD_W = 6,
  parameter int COMP_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_en,
  input  logic [CDF_W+SCGD_W-1:0] ccr,
  input  logic [COMP_W-1:0]       comp,
  input  logic                    scl_in,
  output logic                    scl_low_o,
  output logic                    scl_fall_o,
  output logic                    scl_rise_o,
  output logic                    sample_o,
  output logic                    ref_tick_o
);
  localparam int MAX_HIGH = 10 + 4 * ((1 << SCGD_W) - 1) + ((1 << COMP_W) - 1);
  localparam int PH_W     = $clog2(MAX_HIGH + 1);

  logic             load;
  logic             hold;
  logic             ref_tick;
  logic [CDF_W-1:0] cdf_act;
  logic [PH_W-1:0]  low_len;
  logic [PH_W-1:0]  high_len;

  sclk_cfg_latch #(.CDF_W(CDF_W), .SCGD_W(SCGD_W), .COMP_W(COMP_W), .PH_W(PH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load), .ccr(ccr), .comp(comp),
    .cdf_act(cdf_act), .low_len(low_len), .high_len(high_len)
  );

  sclk_prescaler #(.CDF_W(CDF_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(load), .hold(hold),
    .cdf_act(cdf_act), .tick(ref_tick)
  );

  sclk_phase_seq #(.PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .scl_in(scl_in), .tick(ref_tick),
    .low_len(low_len), .high_len(high_len), .load(load), .hold(hold),
    .scl_low_o(scl_low_o), .scl_fall_o(scl_fall_o), .scl_rise_o(scl_rise_o),
    .sample_o(sample_o)
  );

  assign ref_tick_o = ref_tick;
endmodule

// File: rtl/i2c_scl_divider_chk.sv
module i2c_scl_divider_chk #(
  parameter int CDF_W = 3
) (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic scl_low_o,
  input logic scl_fall_o,
  input logic scl_rise_o,
  input logic sample_o,
  input logic ref_tick_o,
  input logic hold
);
  logic [CDF_W+3:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap_q <= '0;
    else if (ref_tick_o || hold) gap_q <= '0;
    else                         gap_q <= gap_q + 1'b1;
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < (CDF_W + 4)'(1 << CDF_W));

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall_o, scl_rise_o, sample_o}));

  assert_fall_drives_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low_o) |-> scl_fall_o);

  assert_fall_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |-> scl_low_o);

  assert_rise_after_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |-> (!scl_low_o && $past(scl_low_o)));

  assert_sample_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> !scl_low_o);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!scl_low_o && !scl_fall_o && !scl_rise_o && !sample_o && !ref_tick_o));
endmodule

bind i2c_scl_divider i2c_scl_divider_chk #(.CDF_W(CDF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .scl_low_o(scl_low_o),
  .scl_fall_o(scl_fall_o), .scl_rise_o(scl_rise_o), .sample_o(sample_o),
  .ref_tick_o(ref_tick_o), .hold(hold)
);

// File: tb/test_i2c_scl_divider.sv
module test_i2c_scl_divider;
  localparam int CDF_W  = 3;
  localparam int SCGD_W = 6;
  localparam int COMP_W = 6;
  localparam int LIM    = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic [CDF_W+SCGD_W-1:0] ccr = '0;
  logic [COMP_W-1:0] comp = '0;
  logic ext_low = 1'b0;
  logic scl_in;
  logic scl_low_o, scl_fall_o, scl_rise_o, sample_o, ref_tick_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  assign scl_in = !scl_low_o && !ext_low;

  i2c_scl_divider #(.CDF_W(CDF_W), .SCGD_W(SCGD_W), .COMP_W(COMP_W)) i_i2c_scl_divider (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ccr(ccr), .comp(comp), .scl_in(scl_in),
    .scl_low_o(scl_low_o), .scl_fall_o(scl_fall_o), .scl_rise_o(scl_rise_o),
    .sample_o(sample_o), .ref_tick_o(ref_tick_o)
  );

  function automatic int low_ticks(input int s);
    return 10 + 4 * s;
  endfunction

  function automatic int high_ticks(input int s, input int r);
    return 10 + 4 * s + r;
  endfunction

  function automatic logic [CDF_W+SCGD_W-1:0] pack(input int s, input int c);
    return (CDF_W+SCGD_W)'((s << CDF_W) | c);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_run(input int s, input int c, input int r);
    @(negedge clk);
    ccr = pack(s, c);
    comp = COMP_W'(r);
    run_en = 1'b1;
    @(negedge clk);
    chk("R7 fall strobe on start", int'(scl_fall_o), 1);
    chk("R7 scl driven low on start", int'(scl_low_o), 1);
  endtask

  // Call at the negedge of a fall-strobe cycle; leaves at the next fall strobe.
  task automatic one_period(input int s, input int c, input int r, input int n,
                            input bit upd, input int us, input int uc, input int ur);
    int cnt = 0;
    int tk = 0;
    int samp = -1;
    int d = c + 1;
    int h = high_ticks(s, r);
    while (!scl_rise_o && cnt < LIM) begin
      tk += int'(ref_tick_o);
      @(negedge clk);
      cnt++;
      if (upd && cnt == 1) begin
        ccr = pack(us, uc);
        comp = COMP_W'(ur);
      end
    end
    chk("R3 R1 low phase length", cnt, low_ticks(s) * d);
    chk("R2 ticks in low phase", tk, low_ticks(s));
    cnt = 0;
    ext_low = (n > 0);
    while (cnt < LIM) begin
      @(negedge clk);
      cnt++;
      if (cnt == n) ext_low = 1'b0;
      if (sample_o) samp = cnt;
      if (scl_fall_o) break;
    end
    if (n > 0) chk("R5 stretched high length", cnt, h * d + n);
    else       chk("R4 high phase length", cnt, h * d);
    chk("R6 sample offset", samp, ((h >> 1) + 1) * d + n);
  endtask

  task automatic stop_run();
    int seen = 0;
    @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    chk("R8 scl released after stop", int'(scl_low_o), 0);
    for (int i = 0; i < 40; i++) begin
      seen += int'(scl_fall_o | scl_rise_o | sample_o | ref_tick_o | scl_low_o);
      @(negedge clk);
    end
    chk("R8 idle outputs quiet", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s, c, r, n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 reset scl released", int'(scl_low_o), 0);
    chk("R10 reset strobes low", int'(scl_fall_o | scl_rise_o | sample_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 idle after reset", int'(scl_low_o | scl_fall_o | ref_tick_o), 0);

    // Minimum settings.
    start_run(0, 0, 0);
    one_period(0, 0, 0, 0, 1'b0, 0, 0, 0);
    one_period(0, 0, 0, 0, 1'b0, 0, 0, 0);
    stop_run();

    // Maximum settings.
    start_run(63, 7, 63);
    one_period(63, 7, 63, 0, 1'b0, 0, 0, 0);
    stop_run();

    // R1 packing: distinct nonzero fields.
    start_run(2, 5, 3);
    one_period(2, 5, 3, 0, 1'b0, 0, 0, 0);
    stop_run();

    // R5 stretch with one and several clocks.
    start_run(1, 2, 4);
    one_period(1, 2, 4, 7, 1'b0, 0, 0, 0);
    one_period(1, 2, 4, 1, 1'b0, 0, 0, 0);
    stop_run();

    // R9: change mid-period, takes effect next period.
    start_run(3, 1, 5);
    one_period(3, 1, 5, 0, 1'b1, 7, 4, 20);
    one_period(7, 4, 20, 0, 1'b0, 0, 0, 0);
    stop_run();

    for (int i = 0; i < 8; i++) begin
      s = int'($urandom % 16);
      c = int'($urandom % (1 << CDF_W));
      r = int'($urandom % (1 << COMP_W));
      n = int'($urandom % 6);
      start_run(s, c, r);
      one_period(s, c, r, n, 1'b0, 0, 0, 0);
      one_period(s, c, r, 0, 1'b0, 0, 0, 0);
      stop_run();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule